// File: doc/BRIEF.md
# Two-Dimensional Vector Address Generator

This block produces scratchpad byte addresses for a vector instruction that runs over a nested loop. One start pulse launches a whole pass. The pass has an outer number of rows, and each row has an inner number of elements. Each element gets a destination address and two source addresses. Within a row, every pointer steps by the element size. When a row ends, each pointer also takes its own signed gap. A gap of minus one row length, for example, rewinds a source so that it can be read again, and a gap of one element less makes a sliding window.

In accumulate mode, each row reduces to one destination element. The destination pointer stays fixed for the whole row. At the end of the row it moves by its gap only. The block emits at most one address triple per cycle. Each triple is marked with valid, first-of-row and last-of-row flags. A one-cycle done pulse closes the pass. A stall input freezes everything.

Top module: `vec2d_addr_gen`

## Requirements
- R1: After reset, `valid` and `done` are low, and they stay low until a start is accepted.
- R2: A start accepted while idle, with both counts nonzero, latches all inputs. In the next cycle that is not stalled, the block presents the first triple, which equals the three bases. It then emits exactly inner×outer triples, in row-major order.
- R3: Inside a row, each pointer advances by the element size after each element. `elemSize` 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 select 4 bytes.
- R4: After the last element of a row, each pointer becomes its previous value plus its own step plus its own gap. The gap is read as two's complement, and the result wraps modulo 2^AW.
- R5: `first` is high on column 0 of every row, and `last` is high on the final column of every row. Both flags are qualified by `valid`.
- R6: `done` is high for exactly the one cycle that follows the final element of the final row, and `valid` is low in that cycle.
- R7: A start with an inner count of zero or an outer count of zero raises `done` in the next cycle, and no triple is issued.
- R8: While `stall` is high, `valid` is low, and every pointer and counter holds its value.
- R9: A start that arrives while a pass is running is ignored. The running address stream continues unchanged.
- R10: With an outer count of 1, the output is a plain one-dimensional sequence: base + i×size.
- R11: With `accMode` high, the destination address is constant within a row and moves by the destination gap from one row to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a pass when the block is idle |
| stall | input | 1 | Freezes issue and all state |
| accMode | input | 1 | Row-reducing accumulate mode |
| elemSize | input | 2 | Element size code: 0 = 1 B, 1 = 2 B, 2 or 3 = 4 B |
| innerCount | input | CW | Elements per row |
| outerCount | input | CW | Number of rows |
| dstBase | input | AW | Destination start address |
| srcABase | input | AW | Source A start address |
| srcBBase | input | AW | Source B start address |
| dstGap | input | AW | Destination post-row gap, two's complement |
| srcAGap | input | AW | Source A post-row gap, two's complement |
| srcBGap | input | AW | Source B post-row gap, two's complement |
| valid | output | 1 | A triple is issued this cycle |
| first | output | 1 | Issued element is the first of its row |
| last | output | 1 | Issued element is the last of its row |
| dstAddr | output | AW | Destination byte address |
| srcAAddr | output | AW | Source A byte address |
| srcBAddr | output | AW | Source B byte address |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The hardest situation to reach is a row boundary that coincides with a stall, or with a stray start pulse. In that case the gap addition must happen exactly once, and only when the last element is actually accepted. The stimulus stalls on a random share of cycles and runs many short rows, so that row ends fall on stalled cycles again and again. Some runs also raise start in the middle of a pass with different base values. Negative gaps and bases near the top of the address space push the pointers through wrap-around.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;

  typedef struct packed {
    logic load;    // capture bases and configuration
    logic step;    // accepted element inside a row
    logic rowEnd;  // accepted element that closes a row
  } strobe_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    case (code)
      2'd0:    sizeBytes = 3'd1;
      2'd1:    sizeBytes = 3'd2;
      default: sizeBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/vaddr_ctrl.sv
module vaddr_ctrl
  import vaddr_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          stall,
  input  logic [CW-1:0] innerCount,
  input  logic [CW-1:0] outerCount,
  output strobe_t       strb,
  output logic          valid,
  output logic          first,
  output logic          last,
  output logic          done
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          running;
  logic          doneR;
  logic [CW-1:0] colCnt, rowCnt, innerLat, outerLat;
  logic          zeroReq, accept, atRowEnd, atFinal, launch;

  assign zeroReq  = (innerCount == '0) || (outerCount == '0);
  assign launch   = start && !running;
  assign accept   = running && !stall;
  assign atRowEnd = (colCnt == innerLat - ONE);
  assign atFinal  = atRowEnd && (rowCnt == outerLat - ONE);

  assign strb.load   = launch && !zeroReq;
  assign strb.step   = accept && !atRowEnd;
  assign strb.rowEnd = accept && atRowEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      doneR    <= 1'b0;
      colCnt   <= '0;
      rowCnt   <= '0;
      innerLat <= '0;
      outerLat <= '0;
    end else begin
      doneR <= (launch && zeroReq) || (accept && atFinal);
      if (strb.load) begin
        running  <= 1'b1;
        colCnt   <= '0;
        rowCnt   <= '0;
        innerLat <= innerCount;
        outerLat <= outerCount;
      end else if (accept) begin
        if (atRowEnd) begin
          colCnt <= '0;
          rowCnt <= rowCnt + ONE;
          if (atFinal) running <= 1'b0;
        end else begin
          colCnt <= colCnt + ONE;
        end
      end
    end
  end

  assign valid = accept;
  assign first = accept && (colCnt == '0);
  assign last  = accept && atRowEnd;
  assign done  = doneR;

  // R6: the pass end is never reported together with an issued element
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !valid);
  // R6: the final accepted element is followed by done
  p_done_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && atFinal) |=> done);
  // R5: the column counter stays inside the latched row length
  p_col_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (colCnt < innerLat));
  // R8: a stall freezes the counters and keeps the pass alive
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (running && stall) |=> (running && $stable(colCnt) && $stable(rowCnt)));
  // R9: a start while running does not restart the counters
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && stall) |=> $stable(colCnt));

endmodule

// File: rtl/vaddr_dpath.sv
module vaddr_dpath
  import vaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic          accMode,
  input  logic [1:0]    elemSize,
  input  logic [AW-1:0] dstBase,
  input  logic [AW-1:0] srcABase,
  input  logic [AW-1:0] srcBBase,
  input  logic [AW-1:0] dstGap,
  input  logic [AW-1:0] srcAGap,
  input  logic [AW-1:0] srcBGap,
  output logic [AW-1:0] dstAddr,
  output logic [AW-1:0] srcAAddr,
  output logic [AW-1:0] srcBAddr
);
  localparam int NPTR = 3;

  logic [AW-1:0] ptr     [NPTR];
  logic [AW-1:0] gapLat  [NPTR];
  logic [AW-1:0] baseIn  [NPTR];
  logic [AW-1:0] gapIn   [NPTR];
  logic [AW-1:0] stepOf  [NPTR];
  logic [AW-1:0] stepLat;
  logic          accLat;

  assign baseIn[0] = dstBase;  assign gapIn[0] = dstGap;
  assign baseIn[1] = srcABase; assign gapIn[1] = srcAGap;
  assign baseIn[2] = srcBBase; assign gapIn[2] = srcBGap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepLat <= '0;
      accLat  <= 1'b0;
    end else if (strb.load) begin
      stepLat <= AW'(sizeBytes(elemSize));
      accLat  <= accMode;
    end
  end

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    if (i == 0) begin : g_dst
      assign stepOf[i] = accLat ? '0 : stepLat;
    end else begin : g_src
      assign stepOf[i] = stepLat;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptr[i]    <= '0;
        gapLat[i] <= '0;
      end else if (strb.load) begin
        ptr[i]    <= baseIn[i];
        gapLat[i] <= gapIn[i];
      end else if (strb.rowEnd) begin
        ptr[i] <= ptr[i] + stepOf[i] + gapLat[i];
      end else if (strb.step) begin
        ptr[i] <= ptr[i] + stepOf[i];
      end
    end
  end

  assign dstAddr  = ptr[0];
  assign srcAAddr = ptr[1];
  assign srcBAddr = ptr[2];

  // R3: an in-row step moves source A by exactly the element size
  p_step_size_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (srcAAddr == $past(srcAAddr) + $past(stepLat)));
  // R11: the accumulate destination does not move inside a row
  p_acc_fixed_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && accLat) |=> $stable(dstAddr));
  // R8: with no strobe every pointer holds
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step && !strb.rowEnd) |=>
      ($stable(dstAddr) && $stable(srcAAddr) && $stable(srcBAddr)));

endmodule

// File: rtl/vec2d_addr_gen.sv
module vec2d_addr_gen
  import vaddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          stall,
  input  logic          accMode,
  input  logic [1:0]    elemSize,
  input  logic [CW-1:0] innerCount,
  input  logic [CW-1:0] outerCount,
  input  logic [AW-1:0] dstBase,
  input  logic [AW-1:0] srcABase,
  input  logic [AW-1:0] srcBBase,
  input  logic [AW-1:0] dstGap,
  input  logic [AW-1:0] srcAGap,
  input  logic [AW-1:0] srcBGap,
  output logic          valid,
  output logic          first,
  output logic          last,
  output logic [AW-1:0] dstAddr,
  output logic [AW-1:0] srcAAddr,
  output logic [AW-1:0] srcBAddr,
  output logic          done
);
  strobe_t strb;

  vaddr_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stall(stall),
    .innerCount(innerCount), .outerCount(outerCount),
    .strb(strb), .valid(valid), .first(first), .last(last), .done(done)
  );

  vaddr_dpath #(.AW(AW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .accMode(accMode), .elemSize(elemSize),
    .dstBase(dstBase), .srcABase(srcABase), .srcBBase(srcBBase),
    .dstGap(dstGap), .srcAGap(srcAGap), .srcBGap(srcBGap),
    .dstAddr(dstAddr), .srcAAddr(srcAAddr), .srcBAddr(srcBAddr)
  );

  // R1: nothing is issued or finished in the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!valid && !done));

endmodule

// File: tb/vec2d_addr_gen_bench.sv
module vec2d_addr_gen_bench;
  localparam int AW = 16;
  localparam int CW = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, stall = 1'b0, accMode = 1'b0;
  logic [1:0] elemSize = '0;
  logic [CW-1:0] innerCount = '0, outerCount = '0;
  logic [AW-1:0] dstBase = '0, srcABase = '0, srcBBase = '0;
  logic [AW-1:0] dstGap = '0, srcAGap = '0, srcBGap = '0;
  logic valid, first, last, done;
  logic [AW-1:0] dstAddr, srcAAddr, srcBAddr;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vec2d_addr_gen #(.AW(AW), .CW(CW)) u_vec2d_addr_gen (
    .clk(clk), .rstN(rstN), .start(start), .stall(stall), .accMode(accMode),
    .elemSize(elemSize), .innerCount(innerCount), .outerCount(outerCount),
    .dstBase(dstBase), .srcABase(srcABase), .srcBBase(srcBBase),
    .dstGap(dstGap), .srcAGap(srcAGap), .srcBGap(srcBGap),
    .valid(valid), .first(first), .last(last),
    .dstAddr(dstAddr), .srcAAddr(srcAAddr), .srcBAddr(srcBAddr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int szOf(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  // expected address of element (r, c) for a pointer with the given step and gap
  function automatic logic [AW-1:0] expAddr(input int base, input int inner,
      input int step, input int gap, input int r, input int c);
    int v;
    v = base + r * (inner * step + gap) + c * step;
    return v[AW-1:0];
  endfunction

  task automatic runJob(input int inner, input int outer, input int es,
      input bit acc, input int dB, input int aB, input int bB,
      input int dG, input int aG, input int bG, input int stallPct,
      input bit midStart);
    int r = 0, c = 0, sz, dStep;
    bit expDone = 0, sawDone = 0;
    sz = szOf(es);
    dStep = acc ? 0 : sz;
    @(negedge clk);
    stall = 1'b0; start = 1'b1; accMode = acc; elemSize = es[1:0];
    innerCount = CW'(inner); outerCount = CW'(outer);
    dstBase = dB[AW-1:0]; srcABase = aB[AW-1:0]; srcBBase = bB[AW-1:0];
    dstGap = dG[AW-1:0]; srcAGap = aG[AW-1:0]; srcBGap = bG[AW-1:0];
    for (int it = 0; it < 800 && !sawDone; it++) begin
      @(negedge clk);
      start = 1'b0;
      if (midStart && it == 2) begin
        // R9: stray start with different configuration during the pass
        start = 1'b1; dstBase = 16'h1234; srcABase = 16'h4321; srcBBase = 16'h0F0F;
        innerCount = CW'(2); outerCount = CW'(2); elemSize = 2'd2;
      end
      stall = ($urandom % 100) < stallPct;
      #1;
      if (expDone) begin
        chk(done && !valid, "R6", "done pulse after final element", int'(done), 1);
        sawDone = 1;
      end else begin
        chk(!done, "R6", "done early", int'(done), 0);
        if (stall) chk(!valid, "R8", "valid during stall", int'(valid), 0);
        if (valid) begin
          chk(srcAAddr == expAddr(aB, inner, sz, aG, r, c), "R3/R4", "srcA",
              srcAAddr, expAddr(aB, inner, sz, aG, r, c));
          chk(srcBAddr == expAddr(bB, inner, sz, bG, r, c), "R4", "srcB",
              srcBAddr, expAddr(bB, inner, sz, bG, r, c));
          chk(dstAddr == expAddr(dB, inner, dStep, dG, r, c), acc ? "R11" : "R2",
              "dst", dstAddr, expAddr(dB, inner, dStep, dG, r, c));
          chk(first == (c == 0), "R5", "first", int'(first), int'(c == 0));
          chk(last == (c == inner - 1), "R5", "last", int'(last), int'(c == inner - 1));
          if (c == inner - 1) begin
            c = 0; r++;
            if (r == outer) expDone = 1;
          end else c++;
        end
      end
    end
    chk(sawDone, "R2", "watchdog: pass did not finish", int'(sawDone), 1);
    chk(r == outer, "R2", "row count", r, outer);
    stall = 1'b0;
  endtask

  task automatic zeroJob(input int inner, input int outer);
    @(negedge clk);
    stall = 1'b0; start = 1'b1;
    innerCount = CW'(inner); outerCount = CW'(outer);
    @(negedge clk); start = 1'b0; #1;
    chk(done && !valid, "R7", "done after empty start", int'(done), 1);
    @(negedge clk); #1;
    chk(!done && !valid, "R7", "no issue after empty start", int'(valid), 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", "global timeout", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(!valid && !done, "R1", "quiet during reset", int'(valid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!valid && !done, "R1", "quiet after reset", int'(done), 0);

    // sliding-window accumulate: dst +2 per row, srcA rewinds, srcB slides
    runJob(4, 5, 1, 1, 'h0100, 'h0200, 'h0300, 2, -8, -6, 0, 0);
    runJob(4, 5, 1, 1, 'h0100, 'h0200, 'h0300, 2, -8, -6, 40, 1);
    // R10: one row is a plain 1D sweep
    runJob(7, 1, 2, 0, 'h0040, 'h0080, 'h00C0, 99, -99, 33, 20, 0);
    // one element per row: every element is both first and last
    runJob(1, 6, 0, 0, 'h0010, 'h0020, 'h0030, 3, -1, 5, 30, 0);
    // wrap through the top of the address space, size code 3 = 4 bytes
    runJob(3, 4, 3, 0, 'hFFF0, 'hFFFC, 'h0004, 16, 8, -40, 25, 0);
    // R7: empty passes
    zeroJob(0, 5);
    zeroJob(4, 0);
    zeroJob(0, 0);

    for (int j = 0; j < 40; j++) begin
      int inner, outer;
      inner = 1 + $urandom % 6;
      outer = 1 + $urandom % 5;
      runJob(inner, outer, $urandom % 4, 1'($urandom % 2),
             $urandom % 65536, $urandom % 65536, $urandom % 65536,
             int'($urandom % 81) - 40, int'($urandom % 81) - 40,
             int'($urandom % 81) - 40, 35, (inner * outer >= 4) && ($urandom % 3 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule